// File: doc/BRIEF.md
# AXI4-Lite Word-Addressed Scratch Memory Slave

This block is an AXI4-Lite slave with its own RAM. A master writes words into it and reads them back over the five standard channels. The write side and the read side are separate state machines that share one storage array, so a read can finish while a write is half done.

The write side takes one write address, then one write data beat with its byte strobes, commits the enabled bytes, and answers with a write response. It accepts the next address only after that response has been taken. The read side takes one read address and returns one registered data word with a response on the following cycle. Every address is first rounded down to a word boundary and then folded into the array modulo its size, so no address is ever out of range. The protection inputs are accepted and have no effect. The block never signals an error.

Parameters set the data width, the address width and the memory size in bytes. The memory size must be a power of two and hold at least two words. Reset clears the whole array and drops any transfer in flight.

Top module: `axil_mem_slave`

## Requirements
- R1: After reset, awready and arready are 1, wready, bvalid and rvalid are 0, and every memory word reads as zero.
- R2: The write side takes exactly one address, then one data beat, then offers one response. wready is 1 only after an address handshake. awready stays 0 from the address handshake until the write response handshake.
- R3: On a write, byte lane i (wdata bits 8i+7..8i) is stored only when wstrb bit i is 1. Bytes whose strobe is 0 keep their old value, and lane i maps to byte address aligned_address + i.
- R4: The low log2(DATA_W/8) address bits are ignored. Any address inside a word reaches the same word.
- R5: An aligned address at or above MEM_BYTES wraps to (aligned address mod MEM_BYTES).
- R6: bresp and rresp are always 2'b00 (OKAY) while their valid is high.
- R7: Once bvalid or rvalid is 1, it stays 1 until the matching ready is 1. rdata stays stable during that wait.
- R8: rvalid rises on the cycle after the read address handshake and carries the addressed word. arready stays 0 until the read response handshake.
- R9: awprot and arprot have no effect on the data stored or returned.
- R10: Reset applied during a transfer discards it. Afterwards wready stays 0 until a new address arrives, and no data is written.
- R11: The read side runs on its own. A read completes while the write side is waiting for its data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awprot | input | 3 | Write protection (ignored) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection (ignored) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |

## Verification
The hardest case to reach is a reset that lands while the write side holds an accepted address but has no data yet. Only stalling the data channel between the two handshakes produces that state. The bench accepts an address, withholds wvalid, pulses reset, and then presents a data beat with no address. It checks that wready stays low and that the word reads back as zero. The same stall is used to complete a whole read while the write is parked, which shows that the two sides are independent.

// File: rtl/axil_mem_pkg.sv
// Package: shared constants and state types for the AXI4-Lite memory slave.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package axil_mem_pkg;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        WR_WAIT_ADDR = 2'd0,
        WR_WAIT_DATA = 2'd1,
        WR_SEND_RESP = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_WAIT_ADDR = 1'b0,
        RD_SEND_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/axil_mem_store.sv
// Module: byte-lane storage array, one bank per byte lane.
// Each bank is written on its own strobe, and the read word is registered.
// Assumes DEPTH >= 2, and that the indices are already aligned and wrapped.
module axil_mem_store #(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024,
    localparam int LANES    = DATA_W / 8,
    localparam int DEPTH    = MEM_BYTES / LANES,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_strb,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];
        logic [7:0] rd_q;

        // Clear the bank on reset, otherwise store this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) bank[k] <= 8'h00;
            end else if (wr_en && wr_strb[g]) begin
                bank[wr_idx] <= wr_data[g*8 +: 8];
            end
        end

        // Register this lane's read byte when a read address is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= 8'h00;
            else if (rd_en) rd_q <= bank[rd_idx];
        end

        assign rd_data[g*8 +: 8] = rd_q;
    end

endmodule

// File: rtl/axil_mem_wr_ctrl.sv
// Module: write-side sequencer. Runs address, then data, then response, strictly in turn.
// It latches the word index from the address beat and fires one store enable on the data beat.
// Assumes the master keeps data stable while wvalid is high.
module axil_mem_wr_ctrl
    import axil_mem_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aw_valid,
    output logic             aw_ready,
    input  logic [IDX_W-1:0] aw_idx,
    input  logic             w_valid,
    output logic             w_ready,
    output logic             b_valid,
    input  logic             b_ready,
    output logic             st_en,
    output logic [IDX_W-1:0] st_idx
);

    wr_state_e state_q;

    // Step through the three write phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_WAIT_ADDR;
        end else begin
            unique case (state_q)
                WR_WAIT_ADDR: if (aw_valid) state_q <= WR_WAIT_DATA;
                WR_WAIT_DATA: if (w_valid)  state_q <= WR_SEND_RESP;
                WR_SEND_RESP: if (b_ready)  state_q <= WR_WAIT_ADDR;
                default:                    state_q <= WR_WAIT_ADDR;
            endcase
        end
    end

    // Hold the word index of the accepted address until the data beat arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                  st_idx <= '0;
        else if (aw_valid && aw_ready) st_idx <= aw_idx;
    end

    // Decode the handshake outputs from the phase.
    always_comb begin
        aw_ready = (state_q == WR_WAIT_ADDR);
        w_ready  = (state_q == WR_WAIT_DATA);
        b_valid  = (state_q == WR_SEND_RESP);
        st_en    = w_ready && w_valid;
    end

    AST_WR_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({aw_ready, w_ready, b_valid})); // R2
    AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> (w_ready && !aw_ready)); // R2
    AST_ADDR_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |=> aw_ready); // R2
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> b_valid); // R7

endmodule

// File: rtl/axil_mem_rd_ctrl.sv
// Module: read-side sequencer. Takes one address, starts the registered array read,
// and holds the response until the master takes it.
// Assumes the store registers its read word on rd_en.
module axil_mem_rd_ctrl
    import axil_mem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ar_valid,
    output logic ar_ready,
    output logic r_valid,
    input  logic r_ready,
    output logic rd_en
);

    rd_state_e state_q;

    // Alternate between waiting for an address and offering the response.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  state_q <= RD_WAIT_ADDR;
        else if (state_q == RD_WAIT_ADDR && ar_valid) state_q <= RD_SEND_RESP;
        else if (state_q == RD_SEND_RESP && r_ready)  state_q <= RD_WAIT_ADDR;
    end

    // Decode the handshake outputs from the phase.
    always_comb begin
        ar_ready = (state_q == RD_WAIT_ADDR);
        r_valid  = (state_q == RD_SEND_RESP);
        rd_en    = ar_ready && ar_valid;
    end

    AST_R_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> r_valid); // R8
    AST_AR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> !ar_ready); // R8
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> r_valid); // R7

endmodule

// File: rtl/axil_mem_slave.sv
// Module: AXI4-Lite slave with an internal RAM, the top level.
// Aligns each address down to a word, wraps it by the memory size, and ignores the prot inputs.
// Assumes MEM_BYTES is a power of two, DATA_W is a multiple of 8,
// and ADDR_W covers at least the word index plus the byte offset.
module axil_mem_slave
    import axil_mem_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int MEM_BYTES = 1024,
    localparam int STRB_W   = DATA_W / 8,
    localparam int DEPTH    = MEM_BYTES / STRB_W,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int OFS_W    = $clog2(STRB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [2:0]        s_awprot,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [2:0]        s_arprot,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    logic             st_en;
    logic [IDX_W-1:0] st_idx;
    logic             rd_en;
    logic [IDX_W-1:0] aw_idx;
    logic [IDX_W-1:0] ar_idx;
    logic             unused_bits;

    // Taking only the index bits both aligns the address and wraps it.
    assign aw_idx = s_awaddr[OFS_W +: IDX_W];
    assign ar_idx = s_araddr[OFS_W +: IDX_W];

    // The prot inputs and the address bits outside the index carry no meaning here.
    assign unused_bits = ^{s_awprot, s_arprot, s_awaddr, s_araddr};

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    axil_mem_wr_ctrl #(.IDX_W(IDX_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_valid (s_awvalid),
        .aw_ready (s_awready),
        .aw_idx   (aw_idx),
        .w_valid  (s_wvalid),
        .w_ready  (s_wready),
        .b_valid  (s_bvalid),
        .b_ready  (s_bready),
        .st_en    (st_en),
        .st_idx   (st_idx)
    );

    axil_mem_rd_ctrl u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ar_valid (s_arvalid),
        .ar_ready (s_arready),
        .r_valid  (s_rvalid),
        .r_ready  (s_rready),
        .rd_en    (rd_en)
    );

    axil_mem_store #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_en),
        .wr_idx  (st_idx),
        .wr_data (s_wdata),
        .wr_strb (s_wstrb),
        .rd_en   (rd_en),
        .rd_idx  (ar_idx),
        .rd_data (s_rdata)
    );

    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> $stable(s_rdata)); // R7
    AST_NO_STORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> $past(s_awready) || $past(s_wready)); // R2

endmodule

// File: tb/axil_mem_slave_tb.sv
`timescale 1ns/1ps
module axil_mem_slave_tb_top;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int MEMB   = 1024;
    localparam int LANES  = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0;
    logic [2:0]        awprot = '0;
    logic              awvalid = 1'b0;
    logic              awready;
    logic [DATA_W-1:0] wdata = '0;
    logic [LANES-1:0]  wstrb = '0;
    logic              wvalid = 1'b0;
    logic              wready;
    logic [1:0]        bresp;
    logic              bvalid;
    logic              bready = 1'b0;
    logic [ADDR_W-1:0] araddr = '0;
    logic [2:0]        arprot = '0;
    logic              arvalid = 1'b0;
    logic              arready;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        rresp;
    logic              rvalid;
    logic              rready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit reported = 0;
    logic [7:0] model [MEMB];

    always #2.5 clk = ~clk;

    axil_mem_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_BYTES(MEMB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awprot(awprot), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arprot(arprot), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        end
    endtask

    function automatic int base_of(input logic [31:0] a);
        return int'((a & ~32'(LANES - 1)) % MEMB);
    endfunction

    function automatic logic [31:0] model_word(input logic [31:0] a);
        logic [31:0] w;
        int b = base_of(a);
        for (int i = 0; i < LANES; i++) w[i*8 +: 8] = model[b + i];
        return w;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < MEMB; i++) model[i] = 8'h00;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    // Write one word: address, then data, then response (bready held off for 'hold' cycles).
    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                            input logic [2:0] p, input int hold);
        int b = base_of(a);
        @(negedge clk);
        awaddr = a; awprot = p; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
        chk(wready && !awready, "R2 data phase after address", {30'd0, wready, awready}, 32'h2);
        wdata = d; wstrb = s; wvalid = 1'b1;
        @(negedge clk);
        wvalid = 1'b0;
        chk(bvalid, "R2 response after data", {31'd0, bvalid}, 32'h1);
        chk(bresp == 2'b00, "R6 bresp OKAY", {30'd0, bresp}, 32'h0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(bvalid && !awready, "R7 bvalid held", {30'd0, bvalid, awready}, 32'h2);
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk(awready && !bvalid, "R2 next address after response", {30'd0, awready, bvalid}, 32'h2);
        for (int i = 0; i < LANES; i++) if (s[i]) model[b + i] = d[i*8 +: 8];
    endtask

    // Read one word and return it (rready held off for 'hold' cycles).
    task automatic do_read(input logic [31:0] a, input logic [2:0] p, input int hold,
                           output logic [31:0] got);
        @(negedge clk);
        araddr = a; arprot = p; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        chk(rvalid && !arready, "R8 rvalid one cycle after address", {30'd0, rvalid, arready}, 32'h2);
        chk(rresp == 2'b00, "R6 rresp OKAY", {30'd0, rresp}, 32'h0);
        got = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rvalid && rdata == got, "R7 rvalid and rdata held", rdata, got);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk(arready && !rvalid, "R8 address accepted again after response", {30'd0, arready, rvalid}, 32'h2);
    endtask

    task automatic read_cmp(input logic [31:0] a, input string req);
        logic [31:0] got;
        do_read(a, 3'b000, 0, got);
        chk(got == model_word(a), req, got, model_word(a));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(awready && arready && !wready && !bvalid && !rvalid, "R1 idle outputs after reset",
            {27'd0, awready, arready, wready, bvalid, rvalid}, 32'h18);
        read_cmp(32'h10, "R1 memory zero after reset");
        read_cmp(32'h3FC, "R1 top word zero after reset");
    endtask

    task automatic t_full_and_strobe();
        do_write(32'h40, 32'hA5B6C7D8, 4'hF, 3'b000, 0);
        read_cmp(32'h40, "R3 full word write");
        do_write(32'h40, 32'h11223344, 4'b0101, 3'b000, 0);
        read_cmp(32'h40, "R3 strobes 0101 keep lanes 1 and 3");
        do_write(32'h40, 32'hFFEEDDCC, 4'b1000, 3'b000, 0);
        read_cmp(32'h40, "R3 top lane only");
        do_write(32'h44, 32'h12345678, 4'b0000, 3'b000, 0);
        read_cmp(32'h44, "R3 no strobe changes nothing");
    endtask

    task automatic t_align();
        do_write(32'h83, 32'hCAFEF00D, 4'hF, 3'b000, 0);
        read_cmp(32'h80, "R4 unaligned write lands in aligned word");
        read_cmp(32'h82, "R4 unaligned read returns aligned word");
    endtask

    task automatic t_wrap();
        do_write(32'h420, 32'h0BADBEEF, 4'hF, 3'b000, 0);
        read_cmp(32'h20, "R5 address 0x420 wraps to 0x20");
        do_write(32'hFFFF_FFFE, 32'h5A5A0101, 4'hF, 3'b000, 0);
        read_cmp(32'h3FC, "R5 high address wraps to top word");
    endtask

    task automatic t_prot();
        logic [31:0] g1, g2;
        do_write(32'h100, 32'h77665544, 4'hF, 3'b111, 0);
        do_read(32'h100, 3'b010, 0, g1);
        do_read(32'h100, 3'b101, 0, g2);
        chk(g1 == 32'h77665544 && g2 == g1, "R9 prot ignored", g2, 32'h77665544);
    endtask

    task automatic t_hold();
        logic [31:0] got;
        do_write(32'h200, 32'hDEAD0001, 4'hF, 3'b000, 3);
        do_read(32'h200, 3'b000, 3, got);
        chk(got == model_word(32'h200), "R7 held read data correct", got, model_word(32'h200));
    endtask

    task automatic t_independent();
        logic [31:0] got;
        @(negedge clk);
        awaddr = 32'h300; awvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0;
        do_read(32'h40, 3'b000, 0, got);
        chk(got == model_word(32'h40), "R11 read while write waits for data", got, model_word(32'h40));
        chk(wready, "R11 write still waiting for data", {31'd0, wready}, 32'h1);
        wdata = 32'h31415926; wstrb = 4'hF; wvalid = 1'b1;
        @(negedge clk);
        wvalid = 1'b0; bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        for (int i = 0; i < LANES; i++) model[32'h300 + i] = wdata[i*8 +: 8];
        read_cmp(32'h300, "R11 parked write completes");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        awaddr = 32'h60; awvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0;
        apply_reset();
        chk(awready && !wready, "R10 pending address dropped", {30'd0, awready, wready}, 32'h2);
        wdata = 32'h99999999; wstrb = 4'hF; wvalid = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(!wready && !bvalid, "R10 orphan data not accepted", {30'd0, wready, bvalid}, 32'h0);
        end
        wvalid = 1'b0;
        read_cmp(32'h60, "R10 no write after reset");
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_full_and_strobe();
        t_align();
        t_wrap();
        t_prot();
        t_hold();
        t_independent();
        t_reset_mid();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

endmodule